// File: doc/BRIEF.md
# Table-Indexed Instruction Expander

This block sits in the front end of a core that supports a compact "execute from table" instruction. When the decoder offers a 16-bit instruction, the expander checks it against a fixed match pattern. It then gathers a table index from scattered immediate bits and adds that index to a table base held in a user-mode CSR. The 32-bit entry at the resulting address is read through a simple request/ready memory port.

The fetched word goes back to the core for execution as if it had been fetched in place, but the sequential successor is the compact instruction's PC plus 2. If the fetched word is a jump-and-link, the block also supplies a redirect target. That target keeps the upper PC bits of the current 2 MiB region and takes its low 21 bits from the jump's immediate. It does not add an offset to the PC. If the CSR selects the hardware-table mode, the instruction is reported as illegal. A memory error ends the operation with a fault flag.

Top module: `tblx_expander`

## Requirements
- R1: An offered instruction (`start_i` high while idle) is accepted only when `(insn_i & 16'hE083) == 16'h8000`. Any other instruction causes no memory request and no result pulse.
- R2: The table byte offset is a 12-bit value with bits [1:0] zero. It is filled from instruction bits as follows: offset[11]=insn[8], offset[10]=insn[12], offset[9]=insn[3], offset[8]=insn[9], offset[7:6]=insn[6:5], offset[5]=insn[2], offset[4:3]=insn[11:10], offset[2]=insn[4].
- R3: The fetch address is `{csr[XLEN-1:2],2'b00}` plus the offset. `mem_req_o` rises one cycle after acceptance and stays high, with `mem_addr_o` stable, until a cycle in which `mem_ready_i` is high.
- R4: If CSR bit 0 (hardware-table mode) is set when a matching instruction is accepted, `illegal_o` pulses for one cycle, one cycle after acceptance, and no request is made.
- R5: A fetched word whose bits [6:0] are not 7'b1101111 is presented on `issue_insn_o` with a one-cycle `issue_valid_o` pulse in the cycle after the ready edge, with `redirect_o` low.
- R6: A fetched word with bits [6:0] = 7'b1101111 (jump-and-link) is issued with `redirect_o` high and `redirect_pc_o = {pc[XLEN-1:21], word[31], word[19:12], word[20], word[30:21], 1'b0}`.
- R7: On every issue, `next_pc_o` equals the compact instruction's PC plus 2, modulo 2^XLEN. For a jump-and-link this is also the link value.
- R8: `mem_err_i` high together with `mem_ready_i` ends the fetch: `fault_o` pulses for one cycle in the next cycle, no issue follows, and the block returns to idle.
- R9: `start_i` is ignored while a fetch or issue is in progress. The pending address and the result are unaffected.
- R10: After reset, and between operations, `mem_req_o`, `issue_valid_o`, `illegal_o` and `fault_o` are low. At most one of the three result pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | A 16-bit instruction is offered this cycle |
| insn_i | input | 16 | Compact instruction |
| pc_i | input | XLEN | PC of the compact instruction |
| tbase_csr_i | input | XLEN | Table-base CSR value; bit 0 selects hardware-table mode |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | XLEN | Table read byte address |
| mem_ready_i | input | 1 | Memory response present |
| mem_err_i | input | 1 | Response is an error (valid with ready) |
| mem_rdata_i | input | 32 | Fetched table entry |
| issue_valid_o | output | 1 | One-cycle pulse: expanded instruction is presented |
| issue_insn_o | output | 32 | Expanded 32-bit instruction |
| redirect_o | output | 1 | Issued word is a jump-and-link; take redirect_pc_o |
| redirect_pc_o | output | XLEN | Region-relative jump target |
| next_pc_o | output | XLEN | Sequential next PC and link value (PC + 2) |
| illegal_o | output | 1 | One-cycle pulse: hardware-table mode, instruction illegal |
| fault_o | output | 1 | One-cycle pulse: table fetch returned an error |

## Verification
Each result has a fixed timing. The request appears one cycle after acceptance. `illegal_o` pulses one cycle after acceptance. The issue or fault pulse follows the edge at which `mem_ready_i` is sampled by one cycle. The driver changes inputs on falling edges, checks the request and address at the falling edge after each rising edge that should have changed them, and pushes the expected result into a queue before raising ready or start. The monitor samples all result pulses on falling edges. It pops and compares an item on every pulse, so a pulse that is early, late, doubled or missing shows up as a mismatch, an unexpected result, or a leftover queue entry.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ISSUE} tblx_state_e;

  localparam logic [15:0] TBLX_MASK  = 16'hE083;
  localparam logic [15:0] TBLX_MATCH = 16'h8000;
  localparam logic [6:0]  OPC_JAL    = 7'b1101111;
  localparam int          OFF_W      = 12;
  localparam int          REGION_W   = 21;
endpackage

// File: rtl/tblx_decode.sv
module tblx_decode
  import tblx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0]     insn_i,
  input  logic [XLEN-1:0] csr_i,
  output logic            hit_o,
  output logic            hw_mode_o,
  output logic [XLEN-1:0] addr_o
);
  logic [OFF_W-1:0] off;
  logic [XLEN-1:0]  base;
  logic             unused_csr;

  assign hit_o     = (insn_i & TBLX_MASK) == TBLX_MATCH;
  assign hw_mode_o = csr_i[0];
  assign unused_csr = csr_i[1];

  // scattered immediate -> word-aligned byte offset
  assign off = {insn_i[8], insn_i[12], insn_i[3], insn_i[9], insn_i[6:5],
                insn_i[2], insn_i[11:10], insn_i[4], 2'b00};

  assign base   = {csr_i[XLEN-1:2], 2'b00};
  assign addr_o = base + XLEN'(off);
endmodule

// File: rtl/tblx_jal_fix.sv
module tblx_jal_fix
  import tblx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     word_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            is_jal_o,
  output logic [XLEN-1:0] target_o
);
  logic [REGION_W-1:0] imm;
  logic [11:0]         unused_bits;

  assign is_jal_o = word_i[6:0] == OPC_JAL;
  assign imm      = {word_i[31], word_i[19:12], word_i[20], word_i[30:21], 1'b0};
  assign target_o = {pc_i[XLEN-1:REGION_W], imm};
  assign unused_bits = {word_i[11:7], 7'(pc_i[REGION_W-1:REGION_W-7])};
endmodule

// File: rtl/tblx_seq.sv
module tblx_seq
  import tblx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            hit_i,
  input  logic            hw_mode_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            mem_ready_i,
  input  logic            mem_err_i,
  input  logic [31:0]     mem_rdata_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [31:0]     word_o,
  output logic [XLEN-1:0] pc_o,
  output logic            issue_o,
  output logic            illegal_o,
  output logic            fault_o
);
  tblx_state_e state_q, state_d;
  logic [XLEN-1:0] addr_q, pc_q;
  logic [31:0]     word_q;
  logic            illegal_q, fault_q;
  logic            accept, resp;

  assign accept = (state_q == ST_IDLE) && start_i && hit_i;
  assign resp   = (state_q == ST_FETCH) && mem_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept && !hw_mode_i) state_d = ST_FETCH;
      ST_FETCH: if (mem_ready_i) state_d = mem_err_i ? ST_IDLE : ST_ISSUE;
      ST_ISSUE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      pc_q      <= '0;
      word_q    <= '0;
      illegal_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= accept && hw_mode_i;
      fault_q   <= resp && mem_err_i;
      if (accept) begin
        addr_q <= addr_i;
        pc_q   <= pc_i;
      end
      if (resp && !mem_err_i) word_q <= mem_rdata_i;
    end
  end

  assign mem_req_o  = state_q == ST_FETCH;
  assign mem_addr_o = addr_q;
  assign word_o     = word_q;
  assign pc_o       = pc_q;
  assign issue_o    = state_q == ST_ISSUE;
  assign illegal_o  = illegal_q;
  assign fault_o    = fault_q;
endmodule

// File: rtl/tblx_expander.sv
module tblx_expander #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [15:0]     insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] tbase_csr_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_ready_i,
  input  logic            mem_err_i,
  input  logic [31:0]     mem_rdata_i,
  output logic            issue_valid_o,
  output logic [31:0]     issue_insn_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            illegal_o,
  output logic            fault_o
);
  logic            hit, hw_mode, is_jal, issue;
  logic [XLEN-1:0] fetch_addr, pc_held, target;
  logic [31:0]     word;

  tblx_decode #(.XLEN(XLEN)) u_decode (
    .insn_i    (insn_i),
    .csr_i     (tbase_csr_i),
    .hit_o     (hit),
    .hw_mode_o (hw_mode),
    .addr_o    (fetch_addr)
  );

  tblx_seq #(.XLEN(XLEN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .hit_i       (hit),
    .hw_mode_i   (hw_mode),
    .addr_i      (fetch_addr),
    .pc_i        (pc_i),
    .mem_ready_i (mem_ready_i),
    .mem_err_i   (mem_err_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .word_o      (word),
    .pc_o        (pc_held),
    .issue_o     (issue),
    .illegal_o   (illegal_o),
    .fault_o     (fault_o)
  );

  tblx_jal_fix #(.XLEN(XLEN)) u_jal (
    .word_i   (word),
    .pc_i     (pc_held),
    .is_jal_o (is_jal),
    .target_o (target)
  );

  assign issue_valid_o = issue;
  assign issue_insn_o  = word;
  assign redirect_o    = issue && is_jal;
  assign redirect_pc_o = target;
  assign next_pc_o     = pc_held + XLEN'(2);
endmodule

// File: rtl/tblx_expander_chk.sv
module tblx_expander_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_ready_i,
  input logic            mem_err_i,
  input logic            issue_valid_o,
  input logic            redirect_o,
  input logic            illegal_o,
  input logic            fault_o
);
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  assert_illegal_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_o);

  assert_issue_after_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> $past(mem_req_o && mem_ready_i && !mem_err_i));

  assert_issue_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> !issue_valid_o);

  assert_redirect_with_issue_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> issue_valid_o);

  assert_fault_after_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(mem_req_o && mem_ready_i && mem_err_i) && !issue_valid_o);

  assert_one_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({issue_valid_o, illegal_o, fault_o}));
endmodule

bind tblx_expander tblx_expander_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_ready_i   (mem_ready_i),
  .mem_err_i     (mem_err_i),
  .issue_valid_o (issue_valid_o),
  .redirect_o    (redirect_o),
  .illegal_o     (illegal_o),
  .fault_o       (fault_o)
);

// File: tb/tblx_expander_bench.sv
`timescale 1ns/1ps
module tblx_expander_bench;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [15:0]     insn = '0;
  logic [XLEN-1:0] pc = '0;
  logic [XLEN-1:0] csr = '0;
  logic            mreq;
  logic [XLEN-1:0] maddr;
  logic            mready = 1'b0;
  logic            merr = 1'b0;
  logic [31:0]     mdata = '0;
  logic            iv, redir, illeg, flt;
  logic [31:0]     iinsn;
  logic [XLEN-1:0] rpc, npc;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    int              kind;   // 0 issue, 1 illegal, 2 fault
    logic [31:0]     word;
    bit              jal;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] nxt;
    string           req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  tblx_expander #(.XLEN(XLEN)) u_tblx_expander (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn), .pc_i(pc),
    .tbase_csr_i(csr), .mem_req_o(mreq), .mem_addr_o(maddr),
    .mem_ready_i(mready), .mem_err_i(merr), .mem_rdata_i(mdata),
    .issue_valid_o(iv), .issue_insn_o(iinsn), .redirect_o(redir),
    .redirect_pc_o(rpc), .next_pc_o(npc), .illegal_o(illeg), .fault_o(flt)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_addr(input logic [15:0] i, input logic [XLEN-1:0] c);
    logic [11:0] o;
    o = '0;
    o[2] = i[4];  o[3] = i[10]; o[4] = i[11]; o[5] = i[2];
    o[6] = i[5];  o[7] = i[6];  o[8] = i[9];  o[9] = i[3];
    o[10] = i[12]; o[11] = i[8];
    return (c & ~XLEN'(3)) + XLEN'(o);
  endfunction

  function automatic logic [XLEN-1:0] exp_tgt(input logic [31:0] w, input logic [XLEN-1:0] p);
    logic [XLEN-1:0] t;
    t = p & ~XLEN'(32'h001F_FFFF);
    t[20] = w[31];
    for (int k = 12; k <= 19; k++) t[k] = w[k];
    t[11] = w[20];
    for (int k = 1; k <= 10; k++) t[k] = w[k + 20];
    return t;
  endfunction

  // monitor: pop and compare on every result pulse
  always @(negedge clk) begin
    if (rst_n && (iv || illeg || flt)) begin
      if (q.size() == 0) begin
        check("R10", "unexpected result pulse", {61'd0, iv, illeg, flt}, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "result kind", {61'd0, iv, illeg, flt},
              e.kind == 0 ? 64'd4 : (e.kind == 1 ? 64'd2 : 64'd1));
        if (e.kind == 0) begin
          check("R5", "issued word", 64'(iinsn), 64'(e.word));
          check("R6", "redirect flag", 64'(redir), 64'(e.jal));
          if (e.jal) check("R6", "redirect target", 64'(rpc), 64'(e.tgt));
          check("R7", "next pc", 64'(npc), 64'(e.nxt));
        end
      end
    end
  end

  task automatic run_op(input logic [15:0] ins, input logic [XLEN-1:0] p,
                        input logic [XLEN-1:0] c, input logic [31:0] w,
                        input int waits, input bit err, input bit poke);
    bit hit;
    exp_t e;
    hit = (ins & 16'hE083) == 16'h8000;
    e.word = w; e.jal = (w[6:0] == 7'b1101111); e.tgt = exp_tgt(w, p);
    e.nxt = p + XLEN'(2);
    @(negedge clk);
    if (hit && c[0]) begin
      e.kind = 1; e.req = "R4"; q.push_back(e);
    end
    insn = ins; pc = p; csr = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!hit || c[0]) begin
      check(hit ? "R4" : "R1", "no request", 64'(mreq), 64'd0);
      repeat (3) begin
        @(negedge clk);
        check(hit ? "R4" : "R1", "still no request", 64'(mreq), 64'd0);
      end
      return;
    end
    check("R3", "request raised", 64'(mreq), 64'd1);
    check("R2", "fetch address", 64'(maddr), 64'(exp_addr(ins, c)));
    for (int k = 0; k < waits; k++) begin
      if (poke && k == 0) begin
        insn = 16'h8000; pc = 32'h0; csr = 32'h0000_4000; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check(poke ? "R9" : "R3", "request held", 64'(mreq), 64'd1);
      check(poke ? "R9" : "R3", "address held", 64'(maddr), 64'(exp_addr(ins, c)));
    end
    e.kind = err ? 2 : 0;
    e.req  = err ? "R8" : (e.jal ? "R6" : "R5");
    q.push_back(e);
    mready = 1'b1; merr = err; mdata = w;
    @(negedge clk);
    mready = 1'b0; merr = 1'b0;
    check(err ? "R8" : "R5", "request dropped", 64'(mreq), 64'd0);
    repeat (2) @(negedge clk);
    check("R10", "idle request low", 64'(mreq), 64'd0);
  endtask

  initial begin
    #200us;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset req", 64'(mreq), 64'd0);
    check("R10", "reset pulses", {61'd0, iv, illeg, flt}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: non-matching encodings
    run_op(16'h8080, 32'h100, 32'h2000_0000, 32'h0, 0, 0, 0);
    run_op(16'h8001, 32'h100, 32'h2000_0000, 32'h0, 0, 0, 0);
    run_op(16'hA000, 32'h100, 32'h2000_0000, 32'h0, 0, 0, 0);
    // R2/R5: all offset bits, CSR bit1 set must be masked
    run_op(16'h9F7C, 32'h0000_1000, 32'h2000_0002, 32'h0020_8233, 0, 0, 0);
    // R2: single scattered bits with waits
    run_op(16'h8100, 32'h0000_2000, 32'h3000_0000, 32'h00C5_8593, 2, 0, 0);
    run_op(16'h8010, 32'h0000_2004, 32'h3000_0000, 32'h4000_0013, 1, 0, 0);
    run_op(16'h9044, 32'h0000_2008, 32'h3000_0000, 32'h0000_0073, 0, 0, 0);
    // R6: jump-and-link rewrite within region
    run_op(16'h8A20, 32'h1234_5678, 32'h4000_0000, 32'hFFF0_F0EF, 1, 0, 0);
    run_op(16'h8608, 32'hFFE0_0010, 32'h4000_0000, 32'h8010_006F, 0, 0, 0);
    // R7: PC wrap
    run_op(16'h8004, 32'hFFFF_FFFE, 32'h5000_0000, 32'h0000_0013, 0, 0, 0);
    // R4: hardware-table mode
    run_op(16'h9F7C, 32'h0000_3000, 32'h2000_0001, 32'h0, 0, 0, 0);
    // R8: error response
    run_op(16'h8040, 32'h0000_4000, 32'h6000_0000, 32'h0, 2, 1, 0);
    // R9: start while busy ignored
    run_op(16'h9800, 32'h0000_5000, 32'h7000_0000, 32'h1234_5013, 3, 0, 1);
    // back-to-back normal after fault
    run_op(16'h8000, 32'h0000_6000, 32'h7000_0000, 32'h0000_0013, 0, 0, 0);

    repeat (4) @(negedge clk);
    check("R10", "all results seen", 64'(q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule